// File: doc/BRIEF.md
# Command-List I2C Master Sequencer

This block is the control core of an I2C master. The transfer is not described by a fixed start/address/data state machine. Software writes a short program of command words into a 16-slot command store and fills a transmit byte queue. A single go pulse then starts the sequencer. It walks the slots from slot 0 upward. For each slot it issues the matching byte-level operation to an attached bus engine: start or repeated start, byte write, byte read, or stop. The engine does the bit timing and the pad handling; this block only tells it what to do.

Each command carries its own byte count and acknowledge policy. On writes, the sequencer compares every acknowledge that comes back against an expected level. On reads, it tells the engine which acknowledge level to send after each byte. Received bytes go into a receive queue. A per-slot done flag records how far the program got. Three raw event flags report an acknowledge mismatch, a lost arbitration and a read that ran too long, and each of these events stops the program at once. A pause command ends a run without a stop condition, so the bus stays held. A later go can then continue with a fresh program that begins with a repeated start.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, `seq_active`, `bus_busy`, `eng_req`, all `irq_raw` bits and all `cmd_done` bits are 0, and both queue levels are 0.
- R2: A command word is {opcode[13:11], count[10:3], ack_send[2], ack_expect[1], ack_check[0]} with opcode 0 = repeated start, 1 = write, 2 = read, 3 = stop, 4 = pause. A go pulse while idle runs the slots in order from slot 0. A go pulse while running is ignored. An all-zero word runs as a repeated start.
- R3: A write command issues `count` byte writes (`eng_op` = 2), each carrying the next transmit-queue byte in queue order. A count of 0 completes the command with no bus operation. A start issues `eng_op` = 0 and a stop issues `eng_op` = 1, whatever their count field holds.
- R4: When ack_check is 1 and the acknowledge returned for a written byte differs from ack_expect, `irq_raw[0]` is set and the sequence halts. No further operations are issued, and later slots stay not-done. When ack_check is 0, mismatches are ignored.
- R5: A read command issues `count` byte reads (`eng_op` = 3) with `eng_ackout` equal to the slot's ack_send bit. Each received byte enters the receive queue in arrival order.
- R6: `bus_busy` rises when a start operation completes and falls when a stop operation completes. A stop ends the sequence.
- R7: A pause command ends the sequence without a stop, so `bus_busy` stays 1. A later go runs the reloaded list from slot 0.
- R8: The done bit of each slot that completes is set. A go clears all done bits. Slots that are not reached stay 0.
- R9: An operation that completes with `eng_arb` = 1 sets `irq_raw[1]`, clears `bus_busy` and halts the sequence.
- R10: When a byte read gets no completion within `tout_limit` waiting cycles, `irq_raw[2]` is set, `eng_req` is dropped and the sequence halts.
- R11: A pulse on `irq_clr_we` clears exactly the `irq_raw` bits that are set in `irq_clr_mask`. A mask of all ones clears every flag.
- R12: Each byte queue holds 32 bytes and reports its level. Writes to a full queue are dropped. A pulse on the queue's flush input empties it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Write enable for the command store |
| cmd_sel | input | 4 | Slot index for the command write |
| cmd_word | input | 14 | Command word to store |
| go | input | 1 | Start pulse for the command list |
| tout_limit | input | 20 | Maximum waiting cycles for one byte read |
| tx_wr | input | 1 | Push a byte into the transmit queue |
| tx_data | input | 8 | Byte to push |
| tx_rst | input | 1 | Flush the transmit queue |
| tx_level | output | 6 | Transmit queue fill level |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| rx_rst | input | 1 | Flush the receive queue |
| rx_level | output | 6 | Receive queue fill level |
| irq_clr_we | input | 1 | Apply the clear mask to the raw flags |
| irq_clr_mask | input | 3 | Flags to clear: bit 0 ack error, bit 1 arbitration, bit 2 timeout |
| irq_raw | output | 3 | Raw event flags in the same bit order |
| bus_busy | output | 1 | Bus held between start and stop |
| seq_active | output | 1 | Sequencer is running a list |
| cmd_done | output | 16 | Per-slot done flags |
| eng_req | output | 1 | Operation request to the bus engine, held until completion |
| eng_op | output | 2 | Operation: 0 start, 1 stop, 2 write byte, 3 read byte |
| eng_wbyte | output | 8 | Byte to write |
| eng_ackout | output | 1 | Acknowledge level to send after a read byte |
| eng_done | input | 1 | One-cycle completion from the engine |
| eng_rbyte | input | 8 | Byte received, valid with completion |
| eng_ackin | input | 1 | Acknowledge level sampled after a written byte |
| eng_arb | input | 1 | Arbitration lost, valid with completion |

## Verification
The hardest conditions to reach are the ones that cut a program off part way: a mismatched acknowledge on the second of three bytes, an arbitration loss during one chosen operation, and a read that never completes. These must leave exactly the right done bits, queue leftovers and bus-held state. The bench drives these through a behavioural bus engine that counts the operations it accepts. It can be told to return a NACK on one chosen write byte, to report arbitration loss on one chosen operation, or to stall every read. The bench then reads back the flags, done bits and queue levels at the ports after the halt.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

  // command opcodes held in the top three bits of a command word
  typedef enum logic [2:0] {
    OP_RSTART = 3'd0,
    OP_WRITE  = 3'd1,
    OP_READ   = 3'd2,
    OP_STOP   = 3'd3,
    OP_PAUSE  = 3'd4
  } cmd_op_e;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] cnt;
    logic       ack_send;
    logic       ack_expect;
    logic       ack_check;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);

  // byte engine operation codes
  localparam logic [1:0] ENG_START = 2'd0;
  localparam logic [1:0] ENG_STOP  = 2'd1;
  localparam logic [1:0] ENG_WRB   = 2'd2;
  localparam logic [1:0] ENG_RDB   = 2'd3;

  // raw flag bit positions
  localparam int IRQ_ACK  = 0;
  localparam int IRQ_ARB  = 1;
  localparam int IRQ_TOUT = 2;
  localparam int IRQ_N    = 3;

endpackage

// File: rtl/i2cq_cmd_store.sv
module i2cq_cmd_store
  import i2cq_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  cmd_t          wdata,
  input  logic [AW-1:0] raddr,
  output cmd_t          rdata
);

  cmd_t mem [SLOTS];

  // small register file; cleared so that an unwritten slot reads as all zeros
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int DW = 8,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic wr_ok, rd_ok;

  assign wr_ok = wr && (cnt != CW'(DEPTH));
  assign rd_ok = rd && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];
  assign count = cnt;

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH))
    else $error("queue level above depth");

  p_flush_empties_r12: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0))
    else $error("flush did not empty queue");

endmodule

// File: rtl/i2cq_sequencer.sv
module i2cq_sequencer
  import i2cq_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int TOUT_W = 20,
  parameter int LVL_W = 6,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [TOUT_W-1:0] tout_limit,
  output logic [AW-1:0]     pc,
  input  cmd_t              cmd,
  input  logic [7:0]        tx_head,
  input  logic [LVL_W-1:0]  tx_level,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [7:0]        rx_wdata,
  input  logic              irq_clr_we,
  input  logic [IRQ_N-1:0]  irq_clr_mask,
  output logic [IRQ_N-1:0]  irq_raw,
  output logic              bus_busy,
  output logic              seq_active,
  output logic [SLOTS-1:0]  done_q,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [7:0]        eng_wbyte,
  output logic              eng_ackout,
  input  logic              eng_done,
  input  logic [7:0]        eng_rbyte,
  input  logic              eng_ackin,
  input  logic              eng_arb
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_ISSUE, S_WAIT} st_e;

  st_e st;
  logic [7:0] rem;
  logic [TOUT_W-1:0] tcnt;
  logic is_last, ack_bad, arb_hit, tout_hit, cmd_fin, byte_op;

  assign is_last  = (pc == AW'(SLOTS - 1));
  assign byte_op  = (eng_op == ENG_WRB) || (eng_op == ENG_RDB);
  assign arb_hit  = (st == S_WAIT) && eng_done && eng_arb;
  assign ack_bad  = (st == S_WAIT) && eng_done && !eng_arb && (eng_op == ENG_WRB)
                    && cmd.ack_check && (eng_ackin != cmd.ack_expect);
  assign tout_hit = (st == S_WAIT) && !eng_done && (eng_op == ENG_RDB)
                    && (tcnt >= tout_limit);

  // a slot completes either with a zero byte count or on its final operation
  always_comb begin
    cmd_fin = 1'b0;
    if (st == S_ISSUE && (cmd.op == OP_WRITE || cmd.op == OP_READ) && rem == 8'd0)
      cmd_fin = 1'b1;
    if (st == S_WAIT && eng_done && !eng_arb && !ack_bad &&
        (eng_op == ENG_START || (byte_op && rem == 8'd1)))
      cmd_fin = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      pc         <= '0;
      rem        <= '0;
      tcnt       <= '0;
      done_q     <= '0;
      bus_busy   <= 1'b0;
      eng_req    <= 1'b0;
      eng_op     <= ENG_START;
      eng_wbyte  <= '0;
      eng_ackout <= 1'b0;
      tx_pop     <= 1'b0;
      rx_push    <= 1'b0;
      rx_wdata   <= '0;
    end else begin
      tx_pop  <= 1'b0;
      rx_push <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go) begin
            done_q <= '0;
            pc     <= '0;
            st     <= S_LOAD;
          end
        end
        S_LOAD: begin
          rem <= cmd.cnt;
          st  <= S_ISSUE;
        end
        S_ISSUE: begin
          tcnt <= '0;
          case (cmd.op)
            OP_RSTART: begin
              eng_req <= 1'b1;
              eng_op  <= ENG_START;
              st      <= S_WAIT;
            end
            OP_STOP: begin
              eng_req <= 1'b1;
              eng_op  <= ENG_STOP;
              st      <= S_WAIT;
            end
            OP_WRITE: begin
              if (rem != 8'd0) begin
                eng_req   <= 1'b1;
                eng_op    <= ENG_WRB;
                eng_wbyte <= (tx_level == '0) ? 8'h00 : tx_head;
                tx_pop    <= 1'b1;
                st        <= S_WAIT;
              end
            end
            OP_READ: begin
              if (rem != 8'd0) begin
                eng_req    <= 1'b1;
                eng_op     <= ENG_RDB;
                eng_ackout <= cmd.ack_send;
                st         <= S_WAIT;
              end
            end
            default: begin
              // pause and unused codes end the run with the bus left as it is
              done_q[pc] <= 1'b1;
              st         <= S_IDLE;
            end
          endcase
        end
        S_WAIT: begin
          if (arb_hit) begin
            eng_req  <= 1'b0;
            bus_busy <= 1'b0;
            st       <= S_IDLE;
          end else if (eng_done) begin
            eng_req <= 1'b0;
            if (ack_bad) begin
              st <= S_IDLE;
            end else begin
              case (eng_op)
                ENG_START: bus_busy <= 1'b1;
                ENG_STOP: begin
                  bus_busy   <= 1'b0;
                  done_q[pc] <= 1'b1;
                  st         <= S_IDLE;
                end
                ENG_WRB: begin
                  rem <= rem - 8'd1;
                  st  <= S_ISSUE;
                end
                default: begin
                  rem      <= rem - 8'd1;
                  rx_push  <= 1'b1;
                  rx_wdata <= eng_rbyte;
                  st       <= S_ISSUE;
                end
              endcase
            end
          end else if (tout_hit) begin
            eng_req <= 1'b0;
            st      <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase

      if (cmd_fin) begin
        done_q[pc] <= 1'b1;
        if (is_last) begin
          st <= S_IDLE;
        end else begin
          pc <= pc + 1'b1;
          st <= S_LOAD;
        end
      end
    end
  end

  // raw flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_raw <= '0;
    end else begin
      if (irq_clr_we) irq_raw <= irq_raw & ~irq_clr_mask;
      if (ack_bad)  irq_raw[IRQ_ACK]  <= 1'b1;
      if (arb_hit)  irq_raw[IRQ_ARB]  <= 1'b1;
      if (tout_hit) irq_raw[IRQ_TOUT] <= 1'b1;
    end
  end

  assign seq_active = (st != S_IDLE);

  p_op_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_done && !tout_hit) |=> (eng_req && $stable(eng_op) && $stable(eng_wbyte)))
    else $error("engine request changed before completion");

  p_busy_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_busy) |-> ($past(eng_done) && $past(eng_op) == ENG_START))
    else $error("bus_busy rose without a completed start");

  p_ack_flag_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_raw[IRQ_ACK]) |-> $past(eng_done && eng_op == ENG_WRB))
    else $error("ack flag without a completed write");

  p_halt_on_ack_r4: assert property (@(posedge clk) disable iff (rst)
    ack_bad |=> (!seq_active && !eng_req))
    else $error("sequence kept running after ack mismatch");

  p_tout_drop_r10: assert property (@(posedge clk) disable iff (rst)
    tout_hit |=> (!eng_req && !seq_active && irq_raw[IRQ_TOUT]))
    else $error("timeout did not halt the sequence");

  p_idle_done_r8: assert property (@(posedge clk) disable iff (rst)
    (!seq_active && !go) |=> ((done_q & ~$past(done_q)) == '0))
    else $error("done bit set while idle");

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2cq_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int FIFO_DEPTH = 32,
  parameter int TOUT_W = 20,
  localparam int SEL_W = $clog2(SLOTS),
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [SEL_W-1:0]  cmd_sel,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              go,
  input  logic [TOUT_W-1:0] tout_limit,
  input  logic              tx_wr,
  input  logic [7:0]        tx_data,
  input  logic              tx_rst,
  output logic [LVL_W-1:0]  tx_level,
  input  logic              rx_rd,
  output logic [7:0]        rx_data,
  input  logic              rx_rst,
  output logic [LVL_W-1:0]  rx_level,
  input  logic              irq_clr_we,
  input  logic [IRQ_N-1:0]  irq_clr_mask,
  output logic [IRQ_N-1:0]  irq_raw,
  output logic              bus_busy,
  output logic              seq_active,
  output logic [SLOTS-1:0]  cmd_done,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [7:0]        eng_wbyte,
  output logic              eng_ackout,
  input  logic              eng_done,
  input  logic [7:0]        eng_rbyte,
  input  logic              eng_ackin,
  input  logic              eng_arb
);

  logic [SEL_W-1:0] pc;
  cmd_t cur_cmd;
  logic [7:0] tx_head, rx_wdata;
  logic tx_pop, rx_push;

  i2cq_cmd_store #(.SLOTS(SLOTS)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (cmd_we),
    .waddr (cmd_sel),
    .wdata (cmd_t'(cmd_word)),
    .raddr (pc),
    .rdata (cur_cmd)
  );

  i2cq_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .clr   (tx_rst),
    .wr    (tx_wr),
    .wdata (tx_data),
    .rd    (tx_pop),
    .rdata (tx_head),
    .count (tx_level)
  );

  i2cq_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .clr   (rx_rst),
    .wr    (rx_push),
    .wdata (rx_wdata),
    .rd    (rx_rd),
    .rdata (rx_data),
    .count (rx_level)
  );

  i2cq_sequencer #(.SLOTS(SLOTS), .TOUT_W(TOUT_W), .LVL_W(LVL_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .go           (go),
    .tout_limit   (tout_limit),
    .pc           (pc),
    .cmd          (cur_cmd),
    .tx_head      (tx_head),
    .tx_level     (tx_level),
    .tx_pop       (tx_pop),
    .rx_push      (rx_push),
    .rx_wdata     (rx_wdata),
    .irq_clr_we   (irq_clr_we),
    .irq_clr_mask (irq_clr_mask),
    .irq_raw      (irq_raw),
    .bus_busy     (bus_busy),
    .seq_active   (seq_active),
    .done_q       (cmd_done),
    .eng_req      (eng_req),
    .eng_op       (eng_op),
    .eng_wbyte    (eng_wbyte),
    .eng_ackout   (eng_ackout),
    .eng_done     (eng_done),
    .eng_rbyte    (eng_rbyte),
    .eng_ackin    (eng_ackin),
    .eng_arb      (eng_arb)
  );

endmodule

// File: tb/tb_i2c_cmd_master.sv
module tb_i2c_cmd_master;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst;
  logic cmd_we;
  logic [3:0] cmd_sel;
  logic [13:0] cmd_word;
  logic go;
  logic [19:0] tout_limit;
  logic tx_wr;
  logic [7:0] tx_data;
  logic tx_rst;
  logic [5:0] tx_level;
  logic rx_rd;
  logic [7:0] rx_data;
  logic rx_rst;
  logic [5:0] rx_level;
  logic irq_clr_we;
  logic [2:0] irq_clr_mask;
  logic [2:0] irq_raw;
  logic bus_busy, seq_active;
  logic [15:0] cmd_done;
  logic eng_req;
  logic [1:0] eng_op;
  logic [7:0] eng_wbyte;
  logic eng_ackout;
  logic eng_done;
  logic [7:0] eng_rbyte;
  logic eng_ackin;
  logic eng_arb;

  int checks = 0;
  int errors = 0;

  // engine model state and log
  int op_n, wr_n, rd_n, nack_at, arb_at, lat, m_wait, m_idx;
  bit hang_rd, m_busy;
  logic [1:0] log_op [64];
  logic [7:0] log_wb [64];
  logic       log_ack [64];

  always #(CLK_P/2) clk = ~clk;

  i2c_cmd_master dut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_sel(cmd_sel), .cmd_word(cmd_word),
    .go(go), .tout_limit(tout_limit), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_rst(tx_rst), .tx_level(tx_level), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_rst(rx_rst), .rx_level(rx_level), .irq_clr_we(irq_clr_we),
    .irq_clr_mask(irq_clr_mask), .irq_raw(irq_raw), .bus_busy(bus_busy),
    .seq_active(seq_active), .cmd_done(cmd_done), .eng_req(eng_req),
    .eng_op(eng_op), .eng_wbyte(eng_wbyte), .eng_ackout(eng_ackout),
    .eng_done(eng_done), .eng_rbyte(eng_rbyte), .eng_ackin(eng_ackin),
    .eng_arb(eng_arb)
  );

  // behavioural byte engine, acting on falling edges
  initial begin
    eng_done = 0; eng_rbyte = 0; eng_ackin = 0; eng_arb = 0;
    m_busy = 0; m_wait = 0; m_idx = 0;
    forever begin
      @(negedge clk);
      eng_done = 0;
      eng_arb  = 0;
      if (!m_busy) begin
        if (eng_req) begin
          m_busy = 1;
          m_wait = lat;
          m_idx  = op_n;
          if (op_n < 64) begin
            log_op[op_n]  = eng_op;
            log_wb[op_n]  = eng_wbyte;
            log_ack[op_n] = eng_ackout;
          end
          op_n++;
        end
      end else if (!eng_req) begin
        m_busy = 0;
      end else if (m_wait > 0) begin
        m_wait--;
      end else if (hang_rd && eng_op == 2'd3) begin
        m_busy = 1;
      end else begin
        eng_done = 1;
        m_busy = 0;
        if (m_idx == arb_at) eng_arb = 1;
        if (eng_op == 2'd2) begin
          eng_ackin = (wr_n == nack_at);
          wr_n++;
        end
        if (eng_op == 2'd3) begin
          eng_rbyte = 8'hA0 + 8'(rd_n);
          rd_n++;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    op_n = 0; wr_n = 0; rd_n = 0; nack_at = -1; arb_at = -1; hang_rd = 0; lat = 2;
  endtask

  task automatic set_cmd(input int idx, input logic [2:0] op, input logic [7:0] cnt,
                         input logic av, input logic ae, input logic en);
    @(negedge clk);
    cmd_we = 1; cmd_sel = 4'(idx); cmd_word = {op, cnt, av, ae, en};
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    tx_wr = 1; tx_data = b;
    @(negedge clk);
    tx_wr = 0;
  endtask

  task automatic pulse_go();
    @(negedge clk);
    go = 1;
    @(negedge clk);
    go = 0;
  endtask

  task automatic run_seq();
    pulse_go();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!seq_active) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic clr_irq(input logic [2:0] m);
    @(negedge clk);
    irq_clr_we = 1; irq_clr_mask = m;
    @(negedge clk);
    irq_clr_we = 0;
    @(negedge clk);
  endtask

  task automatic pulse_tx_rst();
    @(negedge clk); tx_rst = 1; @(negedge clk); tx_rst = 0; @(negedge clk);
  endtask

  task automatic pulse_rx_rst();
    @(negedge clk); rx_rst = 1; @(negedge clk); rx_rst = 0; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 seq_active", seq_active, 0);
    chk("R1 bus_busy", bus_busy, 0);
    chk("R1 eng_req", eng_req, 0);
    chk("R1 irq_raw", irq_raw, 0);
    chk("R1 cmd_done", cmd_done, 0);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_level", rx_level, 0);
  endtask

  task automatic t_write();
    clear_log();
    set_cmd(0, 3'd0, 8'd9, 0, 0, 0);
    set_cmd(1, 3'd1, 8'd3, 0, 0, 1);
    set_cmd(2, 3'd3, 8'd7, 0, 0, 0);
    push_tx(8'h5A); push_tx(8'h11); push_tx(8'hC3);
    run_seq();
    chk("R3 op count", op_n, 5);
    chk("R3 op0 start", log_op[0], 0);
    chk("R3 op1 write", log_op[1], 2);
    chk("R3 byte0", log_wb[1], 8'h5A);
    chk("R3 byte1", log_wb[2], 8'h11);
    chk("R3 byte2", log_wb[3], 8'hC3);
    chk("R3 op4 stop", log_op[4], 1);
    chk("R8 done write", cmd_done, 16'h0007);
    chk("R6 busy after stop", bus_busy, 0);
    chk("R4 no flag on match", irq_raw, 0);
    chk("R3 tx drained", tx_level, 0);
  endtask

  task automatic t_read_pause();
    clear_log();
    set_cmd(0, 3'd0, 8'd0, 0, 0, 0);
    set_cmd(1, 3'd1, 8'd1, 0, 0, 1);
    set_cmd(2, 3'd2, 8'd2, 0, 0, 0);
    set_cmd(3, 3'd2, 8'd1, 1, 0, 0);
    set_cmd(4, 3'd4, 8'd0, 0, 0, 0);
    push_tx(8'hA1);
    run_seq();
    chk("R5 op count", op_n, 5);
    chk("R5 read op", log_op[2], 3);
    chk("R5 ack byte0", log_ack[2], 0);
    chk("R5 ack byte1", log_ack[3], 0);
    chk("R5 ack last", log_ack[4], 1);
    chk("R5 rx level", rx_level, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R5 rx order", rx_data, 8'hA0 + 8'(k));
      @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
    end
    chk("R8 done read", cmd_done, 16'h001F);
    chk("R7 busy held after pause", bus_busy, 1);
    clear_log();
    set_cmd(0, 3'd0, 8'd0, 0, 0, 0);
    set_cmd(1, 3'd3, 8'd0, 0, 0, 0);
    run_seq();
    chk("R7 continue with start", log_op[0], 0);
    chk("R8 go clears done", cmd_done, 16'h0003);
    chk("R6 busy cleared by stop", bus_busy, 0);
  endtask

  task automatic t_ack();
    clear_log();
    nack_at = 1;
    set_cmd(0, 3'd0, 8'd0, 0, 0, 0);
    set_cmd(1, 3'd1, 8'd3, 0, 0, 1);
    set_cmd(2, 3'd3, 8'd0, 0, 0, 0);
    push_tx(8'h01); push_tx(8'h02); push_tx(8'h03);
    run_seq();
    chk("R4 ack flag", irq_raw, 3'b001);
    chk("R4 ops stop at mismatch", op_n, 3);
    chk("R4 done frozen", cmd_done, 16'h0001);
    chk("R4 bus still held", bus_busy, 1);
    chk("R4 byte left in queue", tx_level, 1);
    clr_irq(3'b010);
    chk("R11 other mask keeps flag", irq_raw, 3'b001);
    clr_irq(3'b001);
    chk("R11 mask clears flag", irq_raw, 0);
    pulse_tx_rst();
    chk("R12 tx flush", tx_level, 0);
    clear_log();
    nack_at = 1;
    set_cmd(1, 3'd1, 8'd3, 0, 0, 0);
    push_tx(8'h01); push_tx(8'h02); push_tx(8'h03);
    run_seq();
    chk("R4 check off no flag", irq_raw, 0);
    chk("R4 check off done", cmd_done, 16'h0007);
    chk("R4 check off ops", op_n, 5);
  endtask

  task automatic t_arb();
    clear_log();
    arb_at = 1;
    set_cmd(0, 3'd0, 8'd0, 0, 0, 0);
    set_cmd(1, 3'd1, 8'd1, 0, 0, 1);
    set_cmd(2, 3'd3, 8'd0, 0, 0, 0);
    push_tx(8'h77);
    run_seq();
    chk("R9 arb flag", irq_raw, 3'b010);
    chk("R9 busy cleared", bus_busy, 0);
    chk("R9 done frozen", cmd_done, 16'h0001);
    chk("R9 ops halted", op_n, 2);
    clr_irq(3'b111);
  endtask

  task automatic t_timeout();
    clear_log();
    hang_rd = 1;
    tout_limit = 20'd20;
    set_cmd(0, 3'd0, 8'd0, 0, 0, 0);
    set_cmd(1, 3'd2, 8'd1, 1, 0, 0);
    set_cmd(2, 3'd3, 8'd0, 0, 0, 0);
    run_seq();
    chk("R10 timeout flag", irq_raw, 3'b100);
    chk("R10 request dropped", eng_req, 0);
    chk("R10 done frozen", cmd_done, 16'h0001);
    chk("R10 ops halted", op_n, 2);
    chk("R10 rx empty", rx_level, 0);
    clr_irq(3'b111);
    chk("R11 all ones clears", irq_raw, 0);
    clear_log();
    lat = 5;
    run_seq();
    chk("R10 slow read within limit", irq_raw, 0);
    chk("R10 slow read done", cmd_done, 16'h0007);
    chk("R10 slow read byte", rx_level, 1);
    pulse_rx_rst();
    chk("R12 rx flush", rx_level, 0);
    tout_limit = 20'd1000;
  endtask

  task automatic t_fifo_full();
    for (int k = 0; k < 33; k++) push_tx(8'(k));
    chk("R12 tx full level", tx_level, 32);
    chk("R12 tx head kept", dut.tx_level, 32);
    pulse_tx_rst();
    chk("R12 tx flush after full", tx_level, 0);
  endtask

  task automatic t_zero_slot();
    clear_log();
    set_cmd(0, 3'd0, 8'd0, 0, 0, 0);
    set_cmd(1, 3'd1, 8'd0, 0, 0, 1);
    set_cmd(2, 3'd4, 8'd0, 0, 0, 0);
    run_seq();
    chk("R2 zero word runs start", log_op[0], 0);
    chk("R3 zero count no op", op_n, 1);
    chk("R3 zero count done", cmd_done, 16'h0007);
    clear_log();
    set_cmd(1, 3'd3, 8'd0, 0, 0, 0);
    run_seq();
    chk("R6 stop releases", bus_busy, 0);
  endtask

  task automatic t_go_ignored();
    clear_log();
    lat = 30;
    set_cmd(0, 3'd0, 8'd0, 0, 0, 0);
    set_cmd(1, 3'd1, 8'd1, 0, 0, 1);
    set_cmd(2, 3'd3, 8'd0, 0, 0, 0);
    push_tx(8'h3C);
    pulse_go();
    repeat (45) @(negedge clk);
    chk("R2 active mid run", seq_active, 1);
    pulse_go();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!seq_active) break;
    end
    repeat (3) @(negedge clk);
    chk("R2 go ignored ops", op_n, 3);
    chk("R2 go ignored done", cmd_done, 16'h0007);
    chk("R2 go ignored byte", log_wb[1], 8'h3C);
  endtask

  initial begin
    rst = 1; cmd_we = 0; cmd_sel = 0; cmd_word = 0; go = 0; tout_limit = 20'd1000;
    tx_wr = 0; tx_data = 0; tx_rst = 0; rx_rd = 0; rx_rst = 0;
    irq_clr_we = 0; irq_clr_mask = 0;
    clear_log();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_write();
    t_read_pause();
    t_ack();
    t_arb();
    t_timeout();
    t_fifo_full();
    t_zero_slot();
    t_go_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule